// File: doc/BRIEF.md
# Transmit Completion Status Queue

This block keeps a short first-in first-out record of finished transmissions. The transmit datapath reports each completion with a valid strobe and four outcome flags: interrupt on success requested, jabber, underrun and maximum collisions. The block turns the report into one status byte and stores it. The host always sees the oldest stored byte on a read port. A host write to the status register removes that byte. When no entry is stored, the read port shows zero.

A report that arrives while the queue is full is dropped. Its loss is recorded by setting an overflow bit in the newest stored entry. Jabber and underrun outcomes leave the transmitter blocked, and it stays blocked until a transmitter reset arrives. That reset also clears the queue. Any stored report that carries an outcome flag raises a one-cycle completion event that can feed an interrupt.

The queue depth is a parameter. The default depth is four entries.

Top module: `txstat_queue`

## Requirements
- R1: The presented byte has this layout: bit 7 complete (always 1 in a stored entry), bit 6 interrupt requested, bit 5 jabber, bit 4 underrun, bit 3 maximum collisions, bit 2 overflow, and bits 1..0 always 0. The report flags enter on `cpl_flags_i` as [3] interrupt requested, [2] jabber, [1] underrun, [0] maximum collisions.
- R2: While `rst_n` is low, and while the queue is empty, `stat_o` reads 0x00. Reset also clears `tx_block_o` and `cpl_evt_o`.
- R3: Entries leave in arrival order. An accepted report shows on `stat_o` from the clock edge that samples it onward, once it becomes the oldest entry.
- R4: A cycle with `host_pop_i` high removes the oldest entry. A pop while the queue is empty changes nothing.
- R5: The queue holds DEPTH entries (default 4). A report that arrives while the queue is full and no pop is in progress is discarded. It sets bit 2 of the newest stored entry and leaves every other entry unchanged.
- R6: A pop and a report in the same cycle both take effect, even when the queue is full. In that case no overflow is marked.
- R7: `cpl_evt_o` is high for the cycle after an accepted report that has any of flags [3:0] set. A plain success report gives no event, and neither does a discarded report.
- R8: A jabber or underrun report sets `tx_block_o` from the next cycle. This holds even if the report itself is discarded. `tx_block_o` then stays high until a transmitter reset.
- R9: `tx_reset_i` empties the queue and clears `tx_block_o`. It takes priority over a report or pop in the same cycle, and that report is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpl_valid_i | input | 1 | Completion report strobe from the transmit datapath |
| cpl_flags_i | input | 4 | Report flags: [3] interrupt requested, [2] jabber, [1] underrun, [0] maximum collisions |
| host_pop_i | input | 1 | Host write to the status register; pops the oldest entry |
| tx_reset_i | input | 1 | Transmitter reset; clears the queue and the blocked state |
| stat_o | output | 8 | Oldest status byte, or 0x00 when empty |
| tx_block_o | output | 1 | Transmitter blocked pending reset |
| cpl_evt_o | output | 1 | One-cycle completion event |

## Verification
The following properties are checked on every cycle:
- the shape of the presented byte;
- that the count stays within the depth;
- that a full queue stays full under an unpaired report;
- that a pop on an empty queue is ignored;
- that the blocked state is set and then held;
- that a transmitter reset empties the queue and unblocks the transmitter.

Other behaviour shows only in the bench's scenarios. This covers arrival order and the exact byte values. It also covers which entry receives the overflow mark, and that the mark later surfaces at the head. Finally, it covers the difference between a full queue with a same-cycle pop and one without.

// File: rtl/txstat_pkg.sv
package txstat_pkg;

  // One report as delivered by the transmit datapath.
  typedef struct packed {
    logic want_irq;
    logic jabber;
    logic underrun;
    logic max_coll;
  } txs_rpt_t;

  // One stored queue entry: the report plus the overflow mark.
  typedef struct packed {
    logic want_irq;
    logic jabber;
    logic underrun;
    logic max_coll;
    logic ovf;
  } txs_ent_t;

  function automatic txs_ent_t rpt_to_ent(txs_rpt_t r);
    txs_ent_t e;
    e.want_irq = r.want_irq;
    e.jabber   = r.jabber;
    e.underrun = r.underrun;
    e.max_coll = r.max_coll;
    e.ovf      = 1'b0;
    return e;
  endfunction

  // Bit positions are fixed because host software decodes them.
  function automatic logic [7:0] ent_to_byte(txs_ent_t e);
    return {1'b1, e.want_irq, e.jabber, e.underrun, e.max_coll, e.ovf, 2'b00};
  endfunction

  function automatic logic rpt_blocks(txs_rpt_t r);
    return r.jabber | r.underrun;
  endfunction

  function automatic logic rpt_signals(txs_rpt_t r);
    return r.want_irq | r.jabber | r.underrun | r.max_coll;
  endfunction

endpackage

// File: rtl/txstat_fifo.sv
module txstat_fifo
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     push_i,
  input  txs_ent_t push_ent_i,
  input  logic     pop_i,
  output txs_ent_t head_o,
  output logic     empty_o,
  output logic     push_ok_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] newest_ptr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty;
  logic          pop_ok, push_ok, mark_ovf;
  logic          ptr_en, cnt_en;
  txs_ent_t      slot_arr [DEPTH];

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PW'(1);
  endfunction

  function automatic logic [PW-1:0] ptr_prev(logic [PW-1:0] p);
    return (p == '0) ? PTR_LAST : p - PW'(1);
  endfunction

  assign full       = (cnt_q == CNT_FULL);
  assign empty      = (cnt_q == '0);
  assign newest_ptr = ptr_prev(wr_ptr_q);

  // Acceptance: a same-cycle pop frees the slot a full queue needs.
  assign pop_ok   = pop_i & ~empty & ~clr_i;
  assign push_ok  = push_i & ~clr_i & (~full | pop_ok);
  assign mark_ovf = push_i & ~clr_i & full & ~pop_ok;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (clr_i) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (pop_ok)  rd_ptr_d = ptr_next(rd_ptr_q);
      if (push_ok) wr_ptr_d = ptr_next(wr_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign ptr_en = clr_i | pop_ok | push_ok;
  assign cnt_en = clr_i | (pop_ok ^ push_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
    end else if (ptr_en) begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Datapath slots: no reset, written only under their own enable.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic     wr_new, set_ovf, slot_en;
    txs_ent_t slot_d, slot_q;

    assign wr_new  = push_ok  & (wr_ptr_q   == PW'(gi));
    assign set_ovf = mark_ovf & (newest_ptr == PW'(gi));
    assign slot_en = wr_new | set_ovf;

    always_comb begin
      slot_d = slot_q;
      if (wr_new)       slot_d = push_ent_i;
      else if (set_ovf) slot_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= slot_d;
    end

    assign slot_arr[gi] = slot_q;
  end

  assign head_o    = slot_arr[rd_ptr_q];
  assign empty_o   = empty;
  assign push_ok_o = push_ok;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_i && !pop_i && !clr_i) |=> (cnt_q == CNT_FULL));

  assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_i && !push_i && !clr_i) |=> (cnt_q == '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/txstat_guard.sv
module txstat_guard
  import txstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     rpt_valid_i,
  input  txs_rpt_t rpt_i,
  output logic     blocked_o
);

  logic blocked_q, blocked_d, blocked_en, trip;

  assign trip = rpt_valid_i & rpt_blocks(rpt_i);

  always_comb begin
    blocked_d = blocked_q;
    if (clr_i)     blocked_d = 1'b0;
    else if (trip) blocked_d = 1'b1;
  end

  assign blocked_en = clr_i | trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          blocked_q <= 1'b0;
    else if (blocked_en) blocked_q <= blocked_d;
  end

  assign blocked_o = blocked_q;

  assert_block_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_i && (rpt_i.jabber || rpt_i.underrun) && !clr_i) |=> blocked_o);

  assert_block_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blocked_o && !clr_i) |=> blocked_o);

  assert_block_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !blocked_o);

endmodule

// File: rtl/txstat_event.sv
module txstat_event
  import txstat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push_ok_i,
  input  txs_rpt_t rpt_i,
  output logic     evt_o
);

  logic evt_q, evt_d;

  always_comb evt_d = push_ok_i & rpt_signals(rpt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign evt_o = evt_q;

  assert_evt_needs_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(push_ok_i));

endmodule

// File: rtl/txstat_queue.sv
module txstat_queue
  import txstat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpl_valid_i,
  input  logic [3:0] cpl_flags_i,
  input  logic       host_pop_i,
  input  logic       tx_reset_i,
  output logic [7:0] stat_o,
  output logic       tx_block_o,
  output logic       cpl_evt_o
);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  txs_rpt_t   rpt;
  txs_ent_t   head_ent;
  logic       q_empty, q_push_ok;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign rpt = txs_rpt_t'(cpl_flags_i);

  txstat_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_i      (tx_reset_i),
    .push_i     (cpl_valid_i),
    .push_ent_i (rpt_to_ent(rpt)),
    .pop_i      (host_pop_i),
    .head_o     (head_ent),
    .empty_o    (q_empty),
    .push_ok_o  (q_push_ok)
  );

  txstat_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .clr_i       (tx_reset_i),
    .rpt_valid_i (cpl_valid_i),
    .rpt_i       (rpt),
    .blocked_o   (tx_block_o)
  );

  txstat_event u_event (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .push_ok_i (q_push_ok),
    .rpt_i     (rpt),
    .evt_o     (cpl_evt_o)
  );

  assign stat_o = q_empty ? 8'h00 : ent_to_byte(head_ent);

  assert_byte_shape_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (stat_o[1:0] == 2'b00) && ((stat_o == 8'h00) || stat_o[7]));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_reset_i |=> ((stat_o == 8'h00) && !tx_block_o));

endmodule

// File: tb/txstat_queue_tb_top.sv
`timescale 1ns/1ps
module txstat_queue_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpl_valid_i;
  logic [3:0] cpl_flags_i;
  logic       host_pop_i;
  logic       tx_reset_i;
  logic [7:0] stat_o;
  logic       tx_block_o;
  logic       cpl_evt_o;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  txstat_queue #(.DEPTH(4)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpl_valid_i (cpl_valid_i),
    .cpl_flags_i (cpl_flags_i),
    .host_pop_i  (host_pop_i),
    .tx_reset_i  (tx_reset_i),
    .stat_o      (stat_o),
    .tx_block_o  (tx_block_o),
    .cpl_evt_o   (cpl_evt_o)
  );

  // Row: {req[3:0], tx_reset, valid, flags[3:0], pop, stat[7:0], blocked, event}
  localparam int NV = 38;
  localparam logic [20:0] VEC [NV] = '{
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd7, 1'b0, 1'b1, 4'b1000, 1'b0, 8'h80, 1'b0, 1'b1},
    {4'd3, 1'b0, 1'b1, 4'b0001, 1'b0, 8'h80, 1'b0, 1'b1},
    {4'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 8'hC0, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h88, 1'b0, 1'b0},
    {4'd2, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd7, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b1000, 1'b0, 8'h80, 1'b0, 1'b1},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd5, 1'b0, 1'b1, 4'b0001, 1'b0, 8'h80, 1'b0, 1'b1},
    {4'd5, 1'b0, 1'b1, 4'b1000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd6, 1'b0, 1'b1, 4'b1000, 1'b1, 8'hC0, 1'b0, 1'b1},
    {4'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h80, 1'b0, 1'b0},
    {4'd5, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h8C, 1'b0, 1'b0},
    {4'd6, 1'b0, 1'b0, 4'b0000, 1'b1, 8'hC0, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b1, 4'b0100, 1'b0, 8'hC0, 1'b1, 1'b1},
    {4'd1, 1'b0, 1'b0, 4'b0000, 1'b1, 8'hA0, 1'b1, 1'b0},
    {4'd8, 1'b0, 1'b0, 4'b0000, 1'b0, 8'hA0, 1'b1, 1'b0},
    {4'd9, 1'b1, 1'b1, 4'b0010, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b1, 4'b0010, 1'b0, 8'h90, 1'b1, 1'b1},
    {4'd9, 1'b1, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd1, 1'b0, 1'b1, 4'b1111, 1'b0, 8'hF8, 1'b1, 1'b1},
    {4'd9, 1'b1, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd6, 1'b0, 1'b1, 4'b0001, 1'b1, 8'h88, 1'b0, 1'b1},
    {4'd6, 1'b0, 1'b1, 4'b0000, 1'b1, 8'h80, 1'b0, 1'b0},
    {4'd4, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd3, 1'b0, 1'b1, 4'b0000, 1'b0, 8'h80, 1'b0, 1'b0},
    {4'd8, 1'b0, 1'b1, 4'b0010, 1'b0, 8'h80, 1'b1, 1'b0},
    {4'd5, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h80, 1'b1, 1'b0},
    {4'd5, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h80, 1'b1, 1'b0},
    {4'd5, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h84, 1'b1, 1'b0},
    {4'd2, 1'b0, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b1, 1'b0},
    {4'd9, 1'b1, 1'b0, 4'b0000, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  function automatic string req_tag(logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] st_exp, logic blk_exp, logic evt_exp);
    n_checks++;
    if (stat_o !== st_exp || tx_block_o !== blk_exp || cpl_evt_o !== evt_exp) begin
      n_errors++;
      $display("FAIL %s: stat/blk/evt actual %h/%b/%b expected %h/%b/%b",
               tag, stat_o, tx_block_o, cpl_evt_o, st_exp, blk_exp, evt_exp);
    end
  endtask

  task automatic drive(logic rs, logic v, logic [3:0] fl, logic p);
    @(negedge clk);
    tx_reset_i  = rs;
    cpl_valid_i = v;
    cpl_flags_i = fl;
    host_pop_i  = p;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    n_errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cpl_valid_i = 1'b0;
    cpl_flags_i = 4'b0000;
    host_pop_i = 1'b0;
    tx_reset_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R2", 8'h00, 1'b0, 1'b0);  // reset state
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R2", 8'h00, 1'b0, 1'b0);  // after release, queue empty

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16], VEC[i][15], VEC[i][14:11], VEC[i][10]);
      check(req_tag(VEC[i][20:17]), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // Directed: asynchronous reset with entries stored and transmitter blocked.
    drive(1'b0, 1'b1, 4'b0100, 1'b0);
    check("R8", 8'hA0, 1'b1, 1'b1);
    drive(1'b0, 1'b1, 4'b0001, 1'b0);
    check("R3", 8'hA0, 1'b1, 1'b1);
    @(negedge clk);
    cpl_valid_i = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R2", 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R2", 8'h00, 1'b0, 1'b0);

    // Directed: the overflow mark sticks to the newest entry across repeats.
    for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, 4'b0000, 1'b0);
    drive(1'b0, 1'b1, 4'b0001, 1'b0);
    drive(1'b0, 1'b1, 4'b1000, 1'b0);
    check("R5", 8'h80, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 4'b0000, 1'b1);
    check("R5", 8'h84, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 4'b0000, 1'b1);
    check("R2", 8'h00, 1'b0, 1'b0);

    finish_run();
  end

endmodule